// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the logic-level clock phases for a full-frame CCD with a two-phase vertical register and a two-phase horizontal register, all from one system clock. A single-cycle start request begins a frame. The frame first integrates with the vertical phases parked low. It then reads out every row. For each row the sequencer moves the row down with two vertical pulses, waits a setup gap, and shifts the row out one pixel at a time. A reset-gate strobe and a delayed sample strobe repeat in every pixel period for the whole time the sequencer is busy.

All timing rests on the pixel period, which is a programmable number of system clocks. Integration length, vertical pulse width and setup gap are counted in whole pixel periods, so every edge of the vertical and horizontal phases lines up with a pixel boundary. The strobe width and the sample delay are counted in system clocks inside a period. The configuration inputs are captured at the cycle the start is accepted. The frame geometry (rows per frame, pixel periods per row) is fixed by parameters. Driving the analog clock rails, generating biases and converting the video are handled outside this block.

The state machine has six states. IDLE goes to INTEG on start. INTEG goes to VXA when the integration span ends. VXA goes to VXB after one pulse width, and VXB goes to SETUP after a second pulse width. SETUP goes to SHIFT when the gap ends. When the row is complete, SHIFT goes back to VXA if rows remain, or to IDLE after the last row.

Top module: `ccd_clock_seq`

## Requirements
- R1: After reset and while idle, vclk_a, vclk_b, hclk_b, rgate, samp, frame_start and frame_done are 0, hclk_a is 1, and line_cnt and frame_cnt are 0.
- R2: A start sampled high while idle begins integration in the next cycle. frame_start is high for exactly that one cycle, and both vertical phases stay low for integ × P system clocks (P = pixel period). A start sampled while busy has no effect.
- R3: For each row, vclk_a is high for vw × P clocks, and then vclk_b is high for vw × P clocks starting the cycle vclk_a falls. The two are never high together.
- R4: hclk_a is high in the cycles before and after every falling edge of vclk_b, and whenever vclk_a rises.
- R5: In SHIFT, each pixel period drives hclk_a high for the first P/2 (rounded down) clocks and low for the rest. hclk_b is always the inverse of hclk_a. hclk_a falls PIXELS times per row.
- R6: A frame lasts (integ + LINES × (PIXELS + setup + 2·vw)) × P clocks, measured from the first INTEG cycle to the cycle frame_done is high.
- R7: vclk_b falls LINES times per frame. line_cnt holds the 0-based row index while that row is being transferred.
- R8: While busy, rgate is high for the first rgw clocks of every pixel period, so it rises once per period.
- R9: samp is a one-cycle pulse sdly clocks after rgate falls, provided rgw + sdly < P. It is never high together with rgate.
- R10: frame_done is a one-cycle pulse in the first IDLE cycle after the last pixel of the last row. frame_cnt increments by one at the same time.
- R11: Configuration changes made after start has been accepted do not affect the running frame.
- R12: A pixel period below 2 is used as 2. A zero integ, vw, setup, rgw or sdly is used as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle frame request |
| cfg_pix_per | input | PW | Pixel period in system clocks |
| cfg_integ | input | IW | Integration length in pixel periods |
| cfg_vpulse | input | DW | Vertical pulse width in pixel periods |
| cfg_setup | input | DW | Horizontal setup gap in pixel periods |
| cfg_rg_width | input | RW | Reset-gate strobe width in system clocks |
| cfg_samp_dly | input | RW | Clocks from strobe fall to sample strobe |
| vclk_a | output | 1 | Vertical phase A |
| vclk_b | output | 1 | Vertical phase B; a row lands on its falling edge |
| hclk_a | output | 1 | Horizontal phase A |
| hclk_b | output | 1 | Horizontal phase B |
| rgate | output | 1 | Reset-gate strobe |
| samp | output | 1 | Sample strobe |
| line_cnt | output | LW | Current row index |
| frame_cnt | output | FW | Completed frames |
| frame_start | output | 1 | First integration cycle pulse |
| frame_done | output | 1 | Frame complete pulse |

## Verification
A span counter that stops one period early or late shows up at once as a vertical pulse of the wrong length, or as a row with the wrong number of hclk_a falls. Because a frame is short, it also shows up within one frame as a wrong frame length. A wrong transition out of SHIFT, such as ending after the wrong row, changes the vclk_b fall count and the line_cnt seen at each fall. A phase counter fault moves the rgate width and the samp offset within the first pixel period after start.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_INTEG,
        S_VXA,
        S_VXB,
        S_SETUP,
        S_SHIFT
    } seq_state_t;
endpackage

// File: rtl/ccd_cfg_latch.sv
module ccd_cfg_latch #(
    parameter int PW = 8,
    parameter int IW = 32,
    parameter int DW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] raw_pix_per,
    input  logic [IW-1:0] raw_integ,
    input  logic [DW-1:0] raw_vpulse,
    input  logic [DW-1:0] raw_setup,
    input  logic [RW-1:0] raw_rg_width,
    input  logic [RW-1:0] raw_samp_dly,
    output logic [PW-1:0] pix_per,
    output logic [IW-1:0] integ,
    output logic [DW-1:0] vpulse,
    output logic [DW-1:0] setup,
    output logic [RW-1:0] rg_width,
    output logic [RW-1:0] samp_dly
);
    localparam logic [PW-1:0] MIN_PER = PW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_per  <= MIN_PER;
            integ    <= IW'(1);
            vpulse   <= DW'(1);
            setup    <= DW'(1);
            rg_width <= RW'(1);
            samp_dly <= RW'(1);
        end else if (load) begin
            pix_per  <= (raw_pix_per < MIN_PER) ? MIN_PER : raw_pix_per;
            integ    <= (raw_integ == '0) ? IW'(1) : raw_integ;
            vpulse   <= (raw_vpulse == '0) ? DW'(1) : raw_vpulse;
            setup    <= (raw_setup == '0) ? DW'(1) : raw_setup;
            rg_width <= (raw_rg_width == '0) ? RW'(1) : raw_rg_width;
            samp_dly <= (raw_samp_dly == '0) ? RW'(1) : raw_samp_dly;
        end
    end
endmodule

// File: rtl/ccd_pix_timer.sv
module ccd_pix_timer #(
    parameter int PW = 8,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] period,
    input  logic [RW-1:0] rg_width,
    input  logic [RW-1:0] samp_dly,
    output logic          tick,
    output logic          rgate,
    output logic          samp,
    output logic          first_half
);
    localparam int SW = ((PW > RW) ? PW : RW) + 1;

    logic [PW-1:0] phase;
    logic [SW-1:0] samp_at;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + PW'(1);
        end
    end

    always_comb begin
        samp_at    = SW'(rg_width) + SW'(samp_dly);
        tick       = run && (phase == period - PW'(1));
        rgate      = run && (SW'(phase) < SW'(rg_width));
        samp       = run && (SW'(phase) == samp_at);
        first_half = phase < (period >> 1);
    end
endmodule

// File: rtl/ccd_clock_seq.sv
module ccd_clock_seq
    import ccd_seq_pkg::*;
#(
    parameter int LINES  = 3086,
    parameter int PIXELS = 3103,
    parameter int PW     = 8,
    parameter int IW     = 32,
    parameter int DW     = 16,
    parameter int RW     = 4,
    parameter int FW     = 16,
    parameter int LW     = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [PW-1:0] cfg_pix_per,
    input  logic [IW-1:0] cfg_integ,
    input  logic [DW-1:0] cfg_vpulse,
    input  logic [DW-1:0] cfg_setup,
    input  logic [RW-1:0] cfg_rg_width,
    input  logic [RW-1:0] cfg_samp_dly,
    output logic          vclk_a,
    output logic          vclk_b,
    output logic          hclk_a,
    output logic          hclk_b,
    output logic          rgate,
    output logic          samp,
    output logic [LW-1:0] line_cnt,
    output logic [FW-1:0] frame_cnt,
    output logic          frame_start,
    output logic          frame_done
);
    localparam int XW  = $clog2(PIXELS + 1);
    localparam int CW0 = (IW > DW) ? IW : DW;
    localparam int CW  = (CW0 > XW) ? CW0 : XW;
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES - 1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] span_cnt, span_len;
    logic          span_last, tick, first_half, load, busy;
    logic [PW-1:0] pix_per;
    logic [IW-1:0] integ;
    logic [DW-1:0] vpulse, setup;
    logic [RW-1:0] rg_width, samp_dly;

    assign busy = (state != S_IDLE);
    assign load = (state == S_IDLE) && start;

    ccd_cfg_latch #(.PW(PW), .IW(IW), .DW(DW), .RW(RW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .load(load),
        .raw_pix_per(cfg_pix_per), .raw_integ(cfg_integ),
        .raw_vpulse(cfg_vpulse), .raw_setup(cfg_setup),
        .raw_rg_width(cfg_rg_width), .raw_samp_dly(cfg_samp_dly),
        .pix_per(pix_per), .integ(integ), .vpulse(vpulse),
        .setup(setup), .rg_width(rg_width), .samp_dly(samp_dly)
    );

    ccd_pix_timer #(.PW(PW), .RW(RW)) i_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .period(pix_per),
        .rg_width(rg_width), .samp_dly(samp_dly), .tick(tick),
        .rgate(rgate), .samp(samp), .first_half(first_half)
    );

    // span length of the current state, in pixel periods
    always_comb begin
        unique case (state)
            S_INTEG: span_len = CW'(integ);
            S_VXA,
            S_VXB:   span_len = CW'(vpulse);
            S_SETUP: span_len = CW'(setup);
            S_SHIFT: span_len = CW'(PIXELS);
            default: span_len = CW'(1);
        endcase
        span_last = tick && (span_cnt == span_len - CW'(1));
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start)     state_nx = S_INTEG;
            S_INTEG: if (span_last) state_nx = S_VXA;
            S_VXA:   if (span_last) state_nx = S_VXB;
            S_VXB:   if (span_last) state_nx = S_SETUP;
            S_SETUP: if (span_last) state_nx = S_SHIFT;
            S_SHIFT: if (span_last) state_nx = (line_cnt == LAST_LINE) ? S_IDLE : S_VXA;
            default:                state_nx = S_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            span_cnt    <= '0;
            line_cnt    <= '0;
            frame_cnt   <= '0;
            frame_start <= 1'b0;
            frame_done  <= 1'b0;
        end else begin
            state       <= state_nx;
            frame_start <= load;
            frame_done  <= (state == S_SHIFT) && span_last && (line_cnt == LAST_LINE);
            if (!busy || span_last) begin
                span_cnt <= '0;
            end else if (tick) begin
                span_cnt <= span_cnt + CW'(1);
            end
            if (load) begin
                line_cnt <= '0;
            end else if ((state == S_SHIFT) && span_last) begin
                if (line_cnt == LAST_LINE) begin
                    line_cnt  <= '0;
                    frame_cnt <= frame_cnt + FW'(1);
                end else begin
                    line_cnt <= line_cnt + LW'(1);
                end
            end
        end
    end

    // phase outputs
    always_comb begin
        vclk_a = (state == S_VXA);
        vclk_b = (state == S_VXB);
        hclk_a = (state == S_SHIFT) ? first_half : 1'b1;
        hclk_b = !hclk_a;
    end
endmodule

// File: rtl/ccd_clock_seq_chk.sv
module ccd_clock_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic vclk_a,
    input logic vclk_b,
    input logic hclk_a,
    input logic rgate,
    input logic samp,
    input logic frame_start,
    input logic frame_done
);
    a_r3_no_v_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(vclk_a && vclk_b));
    a_r3_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vclk_a) |-> vclk_b);
    a_r4_h_high_at_row_land: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vclk_b) |-> (hclk_a && $past(hclk_a)));
    a_r4_h_high_at_va_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vclk_a) |-> hclk_a);
    a_r9_samp_apart: assert property (@(posedge clk) disable iff (!rst_n)
        samp |-> !rgate);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

bind ccd_clock_seq ccd_clock_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .vclk_a(vclk_a), .vclk_b(vclk_b),
    .hclk_a(hclk_a), .rgate(rgate), .samp(samp),
    .frame_start(frame_start), .frame_done(frame_done)
);

// File: tb/test_ccd_clock_seq.sv
`timescale 1ns/1ps
module test_ccd_clock_seq;
    localparam int LINES = 4, PIXELS = 6, PW = 8, IW = 16, DW = 8, RW = 4, FW = 8;
    localparam int LW = $clog2(LINES);

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [PW-1:0] cfg_pix_per = '0;
    logic [IW-1:0] cfg_integ = '0;
    logic [DW-1:0] cfg_vpulse = '0, cfg_setup = '0;
    logic [RW-1:0] cfg_rg_width = '0, cfg_samp_dly = '0;
    logic vclk_a, vclk_b, hclk_a, hclk_b, rgate, samp, frame_start, frame_done;
    logic [LW-1:0] line_cnt;
    logic [FW-1:0] frame_cnt;
    int checks = 0, errors = 0, cycles = 0;

    always #2.5 clk = ~clk;

    ccd_clock_seq #(.LINES(LINES), .PIXELS(PIXELS), .PW(PW), .IW(IW), .DW(DW),
                    .RW(RW), .FW(FW)) i_ccd_clock_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_pix_per(cfg_pix_per),
        .cfg_integ(cfg_integ), .cfg_vpulse(cfg_vpulse), .cfg_setup(cfg_setup),
        .cfg_rg_width(cfg_rg_width), .cfg_samp_dly(cfg_samp_dly),
        .vclk_a(vclk_a), .vclk_b(vclk_b), .hclk_a(hclk_a), .hclk_b(hclk_b),
        .rgate(rgate), .samp(samp), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
        .frame_start(frame_start), .frame_done(frame_done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual %0d expected below 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampv(input int v, input int lo);
        return (v < lo) ? lo : v;
    endfunction

    function automatic longint frame_len(input int p, input int ig, input int vw, input int su);
        return longint'(ig + LINES * (PIXELS + su + 2 * vw)) * p;
    endfunction

    task automatic check_idle(input string tag);
        chk(!vclk_a && !vclk_b && hclk_a && !hclk_b && !rgate && !samp
            && !frame_start && !frame_done, tag,
            {vclk_a, vclk_b, hclk_a, hclk_b, rgate, samp, frame_start, frame_done}, 8'b0010_0000);
    endtask

    // runs one frame; inj >= 0 injects a start and new configuration at that cycle
    task automatic run_frame(input int rp, input int ri, input int rv, input int rs,
                             input int rr, input int rd, input int inj);
        int p = clampv(rp, 2), ig = clampv(ri, 1), vw = clampv(rv, 1);
        int su = clampv(rs, 1), rw = clampv(rr, 1), sd = clampv(rd, 1);
        longint exp_n = frame_len(p, ig, vw, su);
        longint periods = exp_n / p;
        longint exp_samp = (rw + sd < p) ? periods : 0;
        int fc0 = int'(frame_cnt);
        longint idx = 0, first_va = -1, done_idx = -1;
        int run_va = 0, run_vb = 0, bad_v = 0, nvf = 0, bad_h = 0, lfalls = 0, bad_line = 0;
        int bad_lc = 0, low_run = 0, bad_duty = 0, rg_rise = 0, rg_run = 0, bad_rg = 0;
        int since = 1000, nsamp = 0, bad_samp = 0, fs_cnt = 0;
        logic pva = 0, pvb = 0, pha = 1, prg = 0;
        cfg_pix_per = PW'(rp); cfg_integ = IW'(ri); cfg_vpulse = DW'(rv);
        cfg_setup = DW'(rs); cfg_rg_width = RW'(rr); cfg_samp_dly = RW'(rd);
        @(negedge clk); start = 1'b1;
        while (done_idx < 0 && idx < 100000) begin
            @(posedge clk); #1;
            if (idx == 0) start = 1'b0;
            if (inj >= 0 && idx == inj) begin
                start = 1'b1; cfg_pix_per = PW'(p + 3); cfg_integ = IW'(ig + 5);
                cfg_vpulse = DW'(vw + 2); cfg_setup = DW'(su + 1);
            end
            if (inj >= 0 && idx == inj + 1) start = 1'b0;
            if (frame_start) fs_cnt++;
            if (idx == 0) chk(frame_start, "R2 frame_start at first cycle", frame_start, 1);
            if (vclk_a && first_va < 0) first_va = idx;
            if (vclk_a && vclk_b) bad_v++;
            if (hclk_b == hclk_a) bad_h++;
            if (vclk_a) run_va++;
            if (pva && !vclk_a) begin
                if (run_va != vw * p || !vclk_b) bad_v++;
                run_va = 0;
            end
            if (vclk_b) run_vb++;
            if (pvb && !vclk_b) begin
                if (run_vb != vw * p) bad_v++;
                run_vb = 0;
                nvf++;
                if (!(pha && hclk_a)) bad_h++;
                if (nvf > 1 && lfalls != PIXELS) bad_line++;
                lfalls = 0;
                if (int'(line_cnt) != nvf - 1) bad_lc++;
            end
            if (pha && !hclk_a) lfalls++;
            if (!hclk_a) low_run++;
            if (!pha && hclk_a) begin
                if (low_run != p - p / 2) bad_duty++;
                low_run = 0;
            end
            if (!prg && rgate) rg_rise++;
            if (rgate) rg_run++;
            if (prg && !rgate) begin
                if (rg_run != rw) bad_rg++;
                rg_run = 0;
                since = 0;
            end else begin
                since++;
            end
            if (samp) begin
                nsamp++;
                if (since != sd || rgate) bad_samp++;
            end
            if (frame_done) done_idx = idx;
            pva = vclk_a; pvb = vclk_b; pha = hclk_a; prg = rgate;
            idx++;
        end
        chk(done_idx == exp_n, "R6 R11 R12 frame length", done_idx, exp_n);
        chk(first_va == longint'(ig) * p, "R2 vertical quiet during integration", first_va, longint'(ig) * p);
        chk(fs_cnt == 1, "R2 single frame_start, busy start ignored", fs_cnt, 1);
        chk(bad_v == 0, "R3 vertical pulse widths and order", bad_v, 0);
        chk(bad_h == 0, "R4 R5 hclk_a high at row landing, complement", bad_h, 0);
        chk(bad_line == 0 && lfalls == PIXELS, "R5 hclk_a falls per row", lfalls, PIXELS);
        chk(bad_duty == 0, "R5 hclk low time per pixel", bad_duty, 0);
        chk(nvf == LINES && bad_lc == 0, "R7 rows per frame and line_cnt", nvf, LINES);
        chk(rg_rise == periods && bad_rg == 0, "R8 rgate once per pixel period", rg_rise, periods);
        chk(nsamp == exp_samp && bad_samp == 0, "R9 sample strobe timing", nsamp, exp_samp);
        chk(int'(frame_cnt) == fc0 + 1, "R10 frame_cnt increment", frame_cnt, fc0 + 1);
        @(posedge clk); #1;
        chk(!frame_done, "R10 frame_done single cycle", frame_done, 0);
        check_idle("R1 idle outputs after frame");
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk(int'(line_cnt) == 0 && int'(frame_cnt) == 0, "R1 counters in reset", frame_cnt, 0);
        check_idle("R1 outputs in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        check_idle("R1 outputs after reset release");
        // directed: nominal even period
        run_frame(8, 3, 2, 2, 2, 3, -1);
        // R12 all-zero configuration clamps
        run_frame(0, 0, 0, 0, 0, 0, -1);
        // R11 and R2: start and new config while busy
        run_frame(6, 2, 1, 3, 1, 2, 9);
        // odd period
        run_frame(5, 1, 1, 1, 1, 1, 40);
        for (int k = 0; k < 4; k++) begin
            int p = 4 + int'($urandom_range(0, 6));
            int rw = 1 + int'($urandom_range(0, 1));
            int sd = 1 + int'($urandom_range(0, p - rw - 2));
            run_frame(p, 1 + int'($urandom_range(0, 5)), 1 + int'($urandom_range(0, 2)),
                      1 + int'($urandom_range(0, 2)), rw, sd, -1);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule